// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers a set of peripheral interrupt lines into one register-mapped unit. A rising edge on any line is recorded in a pending register. If the line is enabled in the mask register, the edge is also recorded in a request register and turned into a single outbound bus write. The write goes to a 32-byte-aligned target taken from the upper bits of a programmable address register. The low five bits of that same register form the write data.

Software reaches the block through a simple register port. Registers are 32 bits wide and big-endian, and accesses may be one, two or four bytes. Every access gets its response in the cycle after it is presented. The pending register is a clear-on-access snapshot. A bus-error bit in the control register stops message delivery without stopping event recording. Outbound messages use a valid/ready write-request port. When several lines fire together, or while the port is stalled, events wait in a per-line queue and leave lowest line first.

Top module: `irq_msg_aggregator`

## Requirements
- R1: A 0-to-1 transition on line n sets bit n of the pending register whether or not the line is masked. A line held high does not set the bit again after it has been cleared.
- R2: A rising edge on a line whose mask bit is 1 sets the matching request-register bit and produces exactly one outbound message. A line whose mask bit is 0 produces none. The request register (offset 0x00) is read-only, and writes to it change nothing.
- R3: A message carries address = address register with bits [4:0] forced to zero, and data = bits [4:0] of the address register zero-extended to 32 bits.
- R4: While control bit 0 (the bus-error bit) is 1, rising edges still update the pending and request registers but produce no message.
- R5: Any read of the pending register (offset 0x08) returns its value and then clears it. Any write to it clears it whatever the data.
- R6: Reading the control register (offset 0x0C) returns bit 0 only, and all other bits read as zero.
- R7: Mask (offset 0x04) and address (offset 0x10) are full 32-bit read/write registers. After reset, the address register holds 0xFFFB0003, every other register reads zero, and no message is valid.
- R8: A mask write that leaves any bit at position NUM_LINES or above set raises the sticky guest_err output, except when the value written is all ones. The value is stored in either case. Only reset clears guest_err.
- R9: host_size 0/1/2 selects 1/2/4 bytes, and size 3 is illegal. The byte at address offset k (k = host_addr[1:0]) travels on bits [31-8k:24-8k] of the data buses. A partial write changes only the addressed bytes, and a read returns zero on unaddressed bytes. An access with an illegal size, or one not aligned to its size, has no effect and returns zero with host_err = 1.
- R10: An access to any word address other than the five listed offsets returns zero, sets host_err = 1 and changes no register.
- R11: While msg_valid is 1 and msg_ready is 0, msg_addr and msg_data stay stable. Edges on several lines, or edges that arrive during a stall, are each delivered once, lowest line first. A second edge on a line whose message is still queued merges with it.
- R12: host_ack is 1 exactly in the cycle after a cycle with host_sel = 1, and host_rdata/host_err are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Peripheral interrupt lines, edge-detected |
| host_sel | input | 1 | Register access request, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Byte address of the access |
| host_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| host_wdata | input | 32 | Write data, big-endian byte lanes |
| host_ack | output | 1 | Response strobe, one cycle after host_sel |
| host_err | output | 1 | Error response for an illegal or unlisted access |
| host_rdata | output | 32 | Read data, big-endian byte lanes |
| msg_valid | output | 1 | Outbound message write request valid |
| msg_ready | input | 1 | Outbound port accepts the message |
| msg_addr | output | 32 | Message target address, 32-byte aligned |
| msg_data | output | 32 | Message payload |
| guest_err | output | 1 | Sticky flag for an out-of-range mask write |

## Verification
The bench steps every line through its edge with the mask off and then on. A design that confused level with edge, or gated pending with the mask, would show extra or missing pending bits and messages. It fires four lines at once under backpressure and re-fires one that is still queued. A wrong queue would drop an event, duplicate the merged line, or let the stalled payload drift. It sweeps every size and offset pair over the address register, where a lane-mapping slip corrupts neighbouring bytes or misses the alignment error. It also walks every unlisted word address, the bus-error gate, and the all-ones exception for the guest-error flag.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int REG_W    = 32;
  localparam int OFF_REQ  = 'h00;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_PEND = 'h08;
  localparam int OFF_CTRL = 'h0C;
  localparam int OFF_ADDR = 'h10;
  localparam logic [REG_W-1:0] ADDR_RESET = 32'hFFFB_0003;

  typedef enum logic [2:0] {
    SEL_REQ,
    SEL_MASK,
    SEL_PEND,
    SEL_CTRL,
    SEL_ADDR,
    SEL_NONE
  } reg_sel_e;

  // Big-endian lane mask: byte at offset k lives on bits [31-8k -: 8].
  function automatic logic [REG_W-1:0] lane_bits(input logic [1:0] off,
                                                 input logic [1:0] size);
    logic [REG_W-1:0] m;
    int nb;
    m  = '0;
    nb = (size == 2'd0) ? 1 : ((size == 2'd1) ? 2 : 4);
    for (int k = 0; k < 4; k++) begin
      if (k >= int'(off) && k < int'(off) + nb) m[31-8*k -: 8] = 8'hFF;
    end
    return m;
  endfunction

  function automatic logic size_legal(input logic [1:0] off,
                                      input logic [1:0] size);
    case (size)
      2'd0:    return 1'b1;
      2'd1:    return (off[0] == 1'b0);
      2'd2:    return (off == 2'd0);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] rise_o
);

  logic [NUM_LINES-1:0] prev_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= irq_in[i];
    end
    assign rise_o[i] = irq_in[i] & ~prev_q[i];
  end

endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
  parameter int NUM_LINES = 16
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic [NUM_LINES-1:0] grant_o,
  output logic                 any_o
);

  logic [NUM_LINES:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_pick
    assign grant_o[i]  = req_i[i] & ~below[i];
    assign below[i+1]  = below[i] | req_i[i];
  end
  assign any_o = below[NUM_LINES];

endmodule

// File: rtl/irqagg_msgq.sv
module irqagg_msgq import irqagg_pkg::*; #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] event_i,
  input  logic [REG_W-1:0]     target_i,
  input  logic                 msg_ready,
  output logic                 msg_valid,
  output logic [REG_W-1:0]     msg_addr,
  output logic [REG_W-1:0]     msg_data
);

  logic [NUM_LINES-1:0] wait_q;
  logic [NUM_LINES-1:0] grant;
  logic                 any_wait;
  logic                 load;

  irqagg_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .req_i   (wait_q),
    .grant_o (grant),
    .any_o   (any_wait)
  );

  assign load = any_wait && (!msg_valid || msg_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      // A fresh edge on the line being loaded survives as a new entry.
      wait_q <= (wait_q & ~(load ? grant : '0)) | event_i;
      if (load) begin
        msg_valid <= 1'b1;
        msg_addr  <= {target_i[REG_W-1:5], 5'b0};
        msg_data  <= {{(REG_W-5){1'b0}}, target_i[4:0]};
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs import irqagg_pkg::*; #(
  parameter int NUM_LINES = 16,
  parameter int AW        = 8,
  parameter int BERR_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic                 host_sel,
  input  logic                 host_wr,
  input  logic [AW-1:0]        host_addr,
  input  logic [1:0]           host_size,
  input  logic [REG_W-1:0]     host_wdata,
  output logic                 host_ack,
  output logic                 host_err,
  output logic [REG_W-1:0]     host_rdata,
  output logic [NUM_LINES-1:0] mask_lines_o,
  output logic [REG_W-1:0]     target_o,
  output logic                 berr_o,
  output logic                 guest_err_o
);

  localparam logic [REG_W-1:0] LINE_BITS = {REG_W{1'b1}} >> (REG_W - NUM_LINES);

  logic [REG_W-1:0]     mask_q;
  logic [REG_W-1:0]     addr_q;
  logic                 berr_q;
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] req_q;
  logic                 gerr_q;

  reg_sel_e         sel;
  logic [AW-1:0]    word_addr;
  logic [REG_W-1:0] lmask;
  logic             acc_ok;
  logic             wr_ok;
  logic [REG_W-1:0] rd_val;
  logic [REG_W-1:0] mask_n;
  logic [REG_W-1:0] addr_n;
  logic [REG_W-1:0] ctrl_n;

  assign word_addr = {host_addr[AW-1:2], 2'b00};

  always_comb begin
    if      (word_addr == AW'(OFF_REQ))  sel = SEL_REQ;
    else if (word_addr == AW'(OFF_MASK)) sel = SEL_MASK;
    else if (word_addr == AW'(OFF_PEND)) sel = SEL_PEND;
    else if (word_addr == AW'(OFF_CTRL)) sel = SEL_CTRL;
    else if (word_addr == AW'(OFF_ADDR)) sel = SEL_ADDR;
    else                                 sel = SEL_NONE;
  end

  assign lmask  = lane_bits(host_addr[1:0], host_size);
  assign acc_ok = host_sel && size_legal(host_addr[1:0], host_size) && (sel != SEL_NONE);
  assign wr_ok  = acc_ok && host_wr;

  assign mask_n = (mask_q & ~lmask) | (host_wdata & lmask);
  assign addr_n = (addr_q & ~lmask) | (host_wdata & lmask);
  assign ctrl_n = host_wdata & lmask;

  always_comb begin
    case (sel)
      SEL_REQ:  rd_val = REG_W'(req_q);
      SEL_MASK: rd_val = mask_q;
      SEL_PEND: rd_val = REG_W'(pend_q);
      SEL_CTRL: rd_val = REG_W'(berr_q) << BERR_BIT;
      SEL_ADDR: rd_val = addr_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      addr_q     <= ADDR_RESET;
      berr_q     <= 1'b0;
      pend_q     <= '0;
      req_q      <= '0;
      gerr_q     <= 1'b0;
      host_ack   <= 1'b0;
      host_err   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= host_sel;
      host_err   <= host_sel && !acc_ok;
      host_rdata <= (acc_ok && !host_wr) ? (rd_val & lmask) : '0;

      if (wr_ok && sel == SEL_MASK) begin
        mask_q <= mask_n;
        if (((mask_n & ~LINE_BITS) != '0) && (mask_n != {REG_W{1'b1}}))
          gerr_q <= 1'b1;
      end
      if (wr_ok && sel == SEL_ADDR) addr_q <= addr_n;
      if (wr_ok && sel == SEL_CTRL && lmask[BERR_BIT]) berr_q <= ctrl_n[BERR_BIT];

      pend_q <= ((acc_ok && sel == SEL_PEND) ? '0 : pend_q) | rise_i;
      req_q  <= req_q | (rise_i & mask_q[NUM_LINES-1:0]);
    end
  end

  assign mask_lines_o = mask_q[NUM_LINES-1:0];
  assign target_o     = addr_q;
  assign berr_o       = berr_q;
  assign guest_err_o  = gerr_q;

endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator import irqagg_pkg::*; #(
  parameter int NUM_LINES = 16,
  parameter int AW        = 8,
  parameter int BERR_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 host_sel,
  input  logic                 host_wr,
  input  logic [AW-1:0]        host_addr,
  input  logic [1:0]           host_size,
  input  logic [31:0]          host_wdata,
  output logic                 host_ack,
  output logic                 host_err,
  output logic [31:0]          host_rdata,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data,
  output logic                 guest_err
);

  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] mask_lines;
  logic [NUM_LINES-1:0] deliver;
  logic [REG_W-1:0]     target;
  logic                 berr;

  irqagg_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .rise_o (rise)
  );

  irqagg_regs #(
    .NUM_LINES (NUM_LINES),
    .AW        (AW),
    .BERR_BIT  (BERR_BIT)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .rise_i       (rise),
    .host_sel     (host_sel),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_size    (host_size),
    .host_wdata   (host_wdata),
    .host_ack     (host_ack),
    .host_err     (host_err),
    .host_rdata   (host_rdata),
    .mask_lines_o (mask_lines),
    .target_o     (target),
    .berr_o       (berr),
    .guest_err_o  (guest_err)
  );

  assign deliver = rise & mask_lines & {NUM_LINES{~berr}};

  irqagg_msgq #(.NUM_LINES(NUM_LINES)) u_msgq (
    .clk       (clk),
    .rst       (rst),
    .event_i   (deliver),
    .target_i  (target),
    .msg_ready (msg_ready),
    .msg_valid (msg_valid),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data)
  );

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_sel,
  input logic [AW-1:0] host_addr,
  input logic          host_ack,
  input logic          host_err,
  input logic [31:0]   host_rdata,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [31:0]   msg_addr,
  input logic [31:0]   msg_data,
  input logic          guest_err
);

  logic [AW-1:0] word;
  logic          listed;

  assign word   = {host_addr[AW-1:2], 2'b00};
  assign listed = (word == AW'('h00)) || (word == AW'('h04)) || (word == AW'('h08)) ||
                  (word == AW'('h0C)) || (word == AW'('h10));

  a_r12_ack_follows: assert property (@(posedge clk) disable iff (rst)
    host_sel |=> host_ack);

  a_r12_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !host_sel |=> !host_ack);

  a_r10_unlisted_err: assert property (@(posedge clk) disable iff (rst)
    (host_sel && !listed) |=> (host_err && host_rdata == 32'h0));

  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  a_r8_guest_sticky: assert property (@(posedge clk) disable iff (rst)
    guest_err |=> guest_err);

endmodule

bind irq_msg_aggregator irqagg_checker #(.AW(AW)) u_irqagg_checker (
  .clk        (clk),
  .rst        (rst),
  .host_sel   (host_sel),
  .host_addr  (host_addr),
  .host_ack   (host_ack),
  .host_err   (host_err),
  .host_rdata (host_rdata),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .guest_err  (guest_err)
);

// File: tb/test_irq_msg_aggregator.sv
module test_irq_msg_aggregator;

  localparam int N  = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic          host_sel = 1'b0;
  logic          host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [1:0]    host_size = 2'd2;
  logic [31:0]   host_wdata = '0;
  logic          host_ack, host_err;
  logic [31:0]   host_rdata;
  logic          msg_valid;
  logic          msg_ready = 1'b1;
  logic [31:0]   msg_addr, msg_data;
  logic          guest_err;

  int total = 0;
  int passed = 0;
  int msg_cnt = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] last_data = '0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_msg_aggregator #(.NUM_LINES(N), .AW(AW)) i_irq_msg_aggregator (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .host_sel(host_sel), .host_wr(host_wr), .host_addr(host_addr),
    .host_size(host_size), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_err(host_err), .host_rdata(host_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .guest_err(guest_err)
  );

  // Message monitor: a transfer happens at the posedge after a valid&ready sample.
  always @(negedge clk) begin
    #1;
    if (!rst && msg_valid && msg_ready) begin
      msg_cnt   <= msg_cnt + 1;
      last_addr <= msg_addr;
      last_data <= msg_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic acc(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    host_sel = 1'b1; host_wr = wr; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_sel = 1'b0;
    rd = host_rdata; er = host_err;
    chk(host_ack === 1'b1, "R12 ack", 32'(host_ack), 32'h1);
  endtask

  task automatic wr32(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, a, 2'd2, d, rd, er);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic er;
    acc(1'b0, a, 2'd2, 32'h0, rd, er);
    chk(rd === exp && er === 1'b0, req, rd, exp);
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk); irq_in = v;
    repeat (2) @(negedge clk);
    irq_in = '0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] bench_lanes(input int off, input int sz);
    logic [31:0] m;
    int nb;
    m = '0;
    nb = 1 << sz;
    for (int k = 0; k < 4; k++)
      if (k >= off && k < off + nb) m[31-8*k -: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          base;
    logic [31:0] held;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // Reset state (R7)
    chk(msg_valid === 1'b0, "R7 msg_valid reset", 32'(msg_valid), 0);
    chk(guest_err === 1'b0, "R7 guest_err reset", 32'(guest_err), 0);
    rd_chk(8'h10, 32'hFFFB0003, "R7 addr reset");
    rd_chk(8'h04, 32'h0, "R7 mask reset");
    rd_chk(8'h08, 32'h0, "R7 pend reset");
    rd_chk(8'h00, 32'h0, "R7 req reset");
    rd_chk(8'h0C, 32'h0, "R7 ctrl reset");

    // Masked sweep: pending set, clear on read, no message (R1, R5, R2)
    for (int n = 0; n < N; n++) begin
      pulse(N'(1) << n);
      rd_chk(8'h08, 32'h1 << n, "R1 pending set while masked");
      rd_chk(8'h08, 32'h0, "R5 pending cleared by read");
    end
    chk(msg_cnt == 0, "R2 no message when masked", 32'(msg_cnt), 0);
    rd_chk(8'h00, 32'h0, "R2 request stays zero when masked");

    // Held-high line does not re-arm (R1)
    @(negedge clk); irq_in = N'(1) << 3;
    repeat (3) @(negedge clk);
    rd_chk(8'h08, 32'h8, "R1 held line first edge");
    repeat (3) @(negedge clk);
    rd_chk(8'h08, 32'h0, "R1 held line no second set");
    @(negedge clk); irq_in = '0;

    // Control register and bus-error gate (R6, R4)
    wr32(8'h0C, 32'hFFFFFFFF);
    rd_chk(8'h0C, 32'h1, "R6 ctrl reads bit0 only");
    wr32(8'h04, 32'h0000FFFF);
    rd_chk(8'h04, 32'h0000FFFF, "R7 mask readback");
    pulse(N'(1) << 5);
    repeat (4) @(negedge clk);
    chk(msg_cnt == 0, "R4 bus error blocks message", 32'(msg_cnt), 0);
    rd_chk(8'h00, 32'h20, "R4 request still recorded");
    rd_chk(8'h08, 32'h20, "R4 pending still recorded");
    wr32(8'h0C, 32'h0);
    rd_chk(8'h0C, 32'h0, "R6 ctrl cleared");

    // Unmasked sweep: one message each, address/data split (R2, R3)
    wr32(8'h10, 32'h12345677);
    rd_chk(8'h10, 32'h12345677, "R7 addr readback");
    for (int n = 0; n < N; n++) begin
      base = msg_cnt;
      pulse(N'(1) << n);
      chk(msg_cnt == base + 1, "R2 one message per edge", 32'(msg_cnt - base), 1);
      chk(last_addr == 32'h12345660, "R3 message address", last_addr, 32'h12345660);
      chk(last_data == 32'h00000017, "R3 message data", last_data, 32'h17);
    end
    rd_chk(8'h00, 32'h0000FFFF, "R2 request accumulates");
    wr32(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0000FFFF, "R2 request write ignored");

    // Pending cleared by any write (R5)
    base = msg_cnt;
    pulse((N'(1) << 2) | (N'(1) << 9));
    chk(msg_cnt == base + 2, "R11 two simultaneous lines", 32'(msg_cnt - base), 2);
    wr32(8'h08, 32'h0);
    rd_chk(8'h08, 32'h0, "R5 pending cleared by write");

    // Backpressure and merging (R11)
    base = msg_cnt;
    @(negedge clk); msg_ready = 1'b0; irq_in = N'(16'h00F0);
    repeat (2) @(negedge clk);
    irq_in = '0;
    repeat (2) @(negedge clk);
    irq_in = N'(1) << 7;
    repeat (2) @(negedge clk);
    irq_in = '0;
    #1;
    held = msg_addr;
    chk(msg_valid === 1'b1, "R11 valid during stall", 32'(msg_valid), 1);
    repeat (8) @(negedge clk);
    #1;
    chk(msg_valid === 1'b1 && msg_addr == held, "R11 stable during stall", msg_addr, held);
    chk(msg_cnt == base, "R11 nothing taken during stall", 32'(msg_cnt - base), 0);
    @(negedge clk); msg_ready = 1'b1;
    repeat (12) @(negedge clk);
    chk(msg_cnt == base + 4, "R11 one per line with merge", 32'(msg_cnt - base), 4);
    chk(msg_valid === 1'b0, "R11 queue drained", 32'(msg_valid), 0);

    // Size/offset sweep on the address register (R9)
    for (int off = 0; off < 4; off++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [31:0] lm;
        logic [31:0] exp;
        bit legal;
        legal = (sz == 0) || (sz == 1 && (off % 2) == 0) || (sz == 2 && off == 0);
        lm  = (sz < 3) ? bench_lanes(off, sz) : 32'h0;
        exp = legal ? (32'hA1B2C3D4 & lm) : 32'h0;
        wr32(8'h10, 32'h0);
        acc(1'b1, AW'(8'h10 + off), 2'(sz), 32'hA1B2C3D4, rd, er);
        chk(er === !legal, "R9 write error flag", 32'(er), 32'(!legal));
        rd_chk(8'h10, exp, "R9 partial write lanes");
        wr32(8'h10, 32'hA1B2C3D4);
        acc(1'b0, AW'(8'h10 + off), 2'(sz), 32'h0, rd, er);
        chk(rd === exp && er === !legal, "R9 partial read lanes", rd, exp);
      end
    end

    // Unlisted offsets (R10)
    wr32(8'h10, 32'h0BADF00D);
    for (int a = 'h14; a < 256; a += 4) begin
      acc(1'b0, AW'(a), 2'd2, 32'h0, rd, er);
      chk(rd === 32'h0 && er === 1'b1, "R10 unlisted read", rd, 32'h0);
    end
    acc(1'b1, 8'h14, 2'd2, 32'hFFFFFFFF, rd, er);
    chk(er === 1'b1, "R10 unlisted write error", 32'(er), 1);
    rd_chk(8'h10, 32'h0BADF00D, "R10 unlisted write no effect");

    // Guest error flag (R8)
    wr32(8'h04, 32'hFFFFFFFF);
    rd_chk(8'h04, 32'hFFFFFFFF, "R8 all-ones mask stored");
    chk(guest_err === 1'b0, "R8 all-ones exempt", 32'(guest_err), 0);
    wr32(8'h04, 32'h00010000);
    rd_chk(8'h04, 32'h00010000, "R8 out-of-range mask stored");
    chk(guest_err === 1'b1, "R8 flag raised", 32'(guest_err), 1);
    wr32(8'h04, 32'h0);
    chk(guest_err === 1'b1, "R8 flag sticky", 32'(guest_err), 1);

    done = 1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

endmodule